// File: doc/BRIEF.md
# Four-Bank Interleaved Block Fetch

This block sits between a cache controller and main memory and moves one four-word cache block per request. Each word of a block has its own bank: word k of every block lives in bank k. A request carries a block address and starts an access in the banks. After the bank access latency, the words come back over a one-word response bus, one word per strobe. The fourth strobe carries a last flag. A write request carries all four words and puts word k into bank k.

Two timing modes exist. In interleaved mode all four banks run one shared access. The words then leave on four consecutive cycles, so a default refill spans 20 cycles: 1 request cycle, 15 access cycles and 4 delivery cycles. In sequential mode the banks are accessed one after another. Each single-word access of ACC_LAT cycles is followed by its own delivery cycle, so the same refill spans 65 cycles. The mode comes from the `seq_mode` input, which is sampled when a request is accepted. The FORCE_SEQ parameter fixes sequential mode at build time. Bank storage is behavioural and belongs to the block.

The controller has three states. IDLE waits for a request. ACCESS counts down the bank latency. XFER is one cycle per word. The transitions are:
- IDLE to ACCESS when a request is accepted.
- ACCESS to XFER when the count reaches zero.
- XFER to XFER on the next word in interleaved mode.
- XFER to ACCESS on the next word in sequential mode.
- XFER to IDLE after the fourth word.

Top module: `ilv_block_fetch`

## Requirements
- R1: After reset, `busy`, `rsp_valid` and `rsp_last` are all 0.
- R2: A request is accepted at a rising edge where `req_valid` is 1 and `busy` is 0, and `busy` is 1 in the following cycle.
- R3: In interleaved mode, counting the request cycle as cycle 1, read word k (k = 0..3) is presented with `rsp_valid` = 1 in cycle ACC_LAT+2+k. With ACC_LAT = 15 this is a 20-cycle refill.
- R4: Word k of a read (k = 0 first) equals word k last written to the same block address, which is held in bank k.
- R5: In sequential mode, counting the request cycle as cycle 1, read word k is presented in cycle 1+(k+1)*(ACC_LAT+1). With ACC_LAT = 15 this is a 65-cycle refill.
- R6: A read gives exactly four strobes, and `rsp_last` is 1 on the fourth strobe only.
- R7: `busy` stays 1 through the cycle of the final word slot and is 0 in the cycle after it. A request raised while `busy` is 1 has no effect on the data, the timing or the stored contents, and it produces no further transfer.
- R8: The mode is taken from `seq_mode` at acceptance. Changing `seq_mode` during a transfer does not change that transfer's timing.
- R9: A write (`req_we` = 1) stores `req_wdata[k*DW +: DW]` into bank k at the block address. It produces no `rsp_valid` strobe, and it keeps `busy` high for the same span as a read in that mode.
- R10: With FORCE_SEQ = 1, transfers use sequential timing even when `seq_mode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seq_mode | input | 1 | 1 selects sequential bank access for the request being accepted |
| req_valid | input | 1 | Request present |
| req_we | input | 1 | 1 = block write, 0 = block read |
| req_addr | input | AW | Block address |
| req_wdata | input | 4*DW | Write block; word k is at bits k*DW +: DW |
| busy | output | 1 | Transfer in progress; requests are ignored while high |
| rsp_valid | output | 1 | Read word strobe |
| rsp_last | output | 1 | Marks the fourth word of a block |
| rsp_data | output | DW | Read word; zero when no strobe |

## Verification
The bench measures, for each word, the exact cycle at which it appears relative to acceptance, in both modes and on a build with FORCE_SEQ set. A design that started the banks one by one in interleaved mode, or dropped the delivery cycle between sequential accesses, would show shifted words or wrong totals. It raises a conflicting write while a read is in flight, then reads back the target block; a controller that accepted mid-transfer would corrupt that block or emit extra strobes. It toggles the mode input mid-transfer and checks the last flag and the busy release. A design that sampled the mode late would switch timing, and one that released busy early would let the next request overlap the final word.

// File: rtl/ilv_fetch_pkg.sv
package ilv_fetch_pkg;

    localparam int NBANK  = 4;
    localparam int WIDX_W = $clog2(NBANK);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_XFER   = 2'd2
    } fetch_state_t;

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
    parameter int DW      = 16,
    parameter int AW      = 6,
    parameter int ACC_LAT = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_we,
    input  logic [AW-1:0] start_addr,
    input  logic [DW-1:0] start_wdata,
    output logic [DW-1:0] rdata,
    output logic          rdy
);

    localparam int CW    = $clog2(ACC_LAT + 1);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [CW-1:0] cnt;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          we_q;
    logic          commit;

    // The access completes on the edge where the countdown leaves 1.
    assign commit = (cnt == CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            rdy     <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
        end else if (start) begin
            cnt     <= CW'(ACC_LAT);
            rdy     <= 1'b0;
            addr_q  <= start_addr;
            wdata_q <= start_wdata;
            we_q    <= start_we;
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
            if (commit) begin
                rdy <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (commit && !start) begin
            if (we_q) begin
                mem[addr_q] <= wdata_q;
            end else begin
                rdata <= mem[addr_q];
            end
        end
    end

endmodule

// File: rtl/ilv_ctrl.sv
module ilv_ctrl
    import ilv_fetch_pkg::*;
#(
    parameter int ACC_LAT   = 15,
    parameter bit FORCE_SEQ = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic              seq_mode,
    output logic              accept,
    output logic              busy,
    output logic              op_we,
    output logic              xfer_valid,
    output logic              xfer_last,
    output logic [WIDX_W-1:0] word_idx,
    output logic [NBANK-1:0]  bank_start
);

    localparam int CW = (ACC_LAT > 1) ? $clog2(ACC_LAT) : 1;
    localparam logic [WIDX_W-1:0] LAST_IDX = WIDX_W'(NBANK - 1);

    fetch_state_t      st, st_n;
    logic [CW-1:0]     cnt, cnt_n;
    logic [WIDX_W-1:0] idx, idx_n;
    logic              seq_q, we_q;
    logic              seq_in;

    generate
        if (FORCE_SEQ) begin : g_fixed_seq
            assign seq_in = 1'b1;
        end else begin : g_run_mode
            assign seq_in = seq_mode;
        end
    endgenerate

    // Next-state logic
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        idx_n = idx;
        unique case (st)
            ST_IDLE: begin
                if (req_valid) begin
                    st_n  = ST_ACCESS;
                    cnt_n = CW'(ACC_LAT - 1);
                    idx_n = '0;
                end
            end
            ST_ACCESS: begin
                if (cnt == '0) begin
                    st_n = ST_XFER;
                end else begin
                    cnt_n = cnt - CW'(1);
                end
            end
            ST_XFER: begin
                if (idx == LAST_IDX) begin
                    st_n = ST_IDLE;
                end else begin
                    idx_n = idx + WIDX_W'(1);
                    if (seq_q) begin
                        st_n  = ST_ACCESS;
                        cnt_n = CW'(ACC_LAT - 1);
                    end
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            idx   <= '0;
            seq_q <= 1'b0;
            we_q  <= 1'b0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            idx <= idx_n;
            if (st == ST_IDLE && req_valid) begin
                seq_q <= seq_in;
                we_q  <= req_we;
            end
        end
    end

    // Outputs
    always_comb begin
        accept     = (st == ST_IDLE) && req_valid;
        busy       = (st != ST_IDLE);
        op_we      = we_q;
        xfer_valid = (st == ST_XFER) && !we_q;
        xfer_last  = xfer_valid && (idx == LAST_IDX);
        word_idx   = idx;
        for (int k = 0; k < NBANK; k++) begin
            bank_start[k] = accept && ((k == 0) || !seq_in);
            if (k > 0) begin
                bank_start[k] = bank_start[k] ||
                    ((st == ST_XFER) && seq_q && (idx == WIDX_W'(k - 1)));
            end
        end
    end

endmodule

// File: rtl/ilv_block_fetch.sv
module ilv_block_fetch
    import ilv_fetch_pkg::*;
#(
    parameter int DW        = 16,
    parameter int AW        = 6,
    parameter int ACC_LAT   = 15,
    parameter bit FORCE_SEQ = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                seq_mode,
    input  logic                req_valid,
    input  logic                req_we,
    input  logic [AW-1:0]       req_addr,
    input  logic [NBANK*DW-1:0] req_wdata,
    output logic                busy,
    output logic                rsp_valid,
    output logic                rsp_last,
    output logic [DW-1:0]       rsp_data
);

    logic                accept;
    logic                op_we;
    logic [WIDX_W-1:0]   word_idx;
    logic [NBANK-1:0]    bank_start;
    logic [NBANK-1:0]    bank_rdy;
    logic [DW-1:0]       bank_rdata [NBANK];
    logic [AW-1:0]       addr_q;
    logic [NBANK*DW-1:0] wdata_q;

    ilv_ctrl #(
        .ACC_LAT   (ACC_LAT),
        .FORCE_SEQ (FORCE_SEQ)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_we     (req_we),
        .seq_mode   (seq_mode),
        .accept     (accept),
        .busy       (busy),
        .op_we      (op_we),
        .xfer_valid (rsp_valid),
        .xfer_last  (rsp_last),
        .word_idx   (word_idx),
        .bank_start (bank_start)
    );

    // Held copy of the request, for banks started after acceptance.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    generate
        for (genvar k = 0; k < NBANK; k++) begin : g_bank
            logic [AW-1:0] b_addr;
            logic [DW-1:0] b_wdata;
            logic          b_we;

            assign b_addr  = accept ? req_addr : addr_q;
            assign b_wdata = accept ? req_wdata[k*DW +: DW] : wdata_q[k*DW +: DW];
            assign b_we    = accept ? req_we : op_we;

            ilv_bank #(
                .DW      (DW),
                .AW      (AW),
                .ACC_LAT (ACC_LAT)
            ) u_bank (
                .clk         (clk),
                .rst_n       (rst_n),
                .start       (bank_start[k]),
                .start_we    (b_we),
                .start_addr  (b_addr),
                .start_wdata (b_wdata),
                .rdata       (bank_rdata[k]),
                .rdy         (bank_rdy[k])
            );
        end
    endgenerate

    assign rsp_data = rsp_valid ? bank_rdata[word_idx] : '0;

endmodule

// File: rtl/ilv_block_fetch_chk.sv
module ilv_block_fetch_chk
    import ilv_fetch_pkg::*;
#(
    parameter int ACC_LAT   = 15,
    parameter bit FORCE_SEQ = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_we,
    input logic              seq_mode,
    input logic              busy,
    input logic              rsp_valid,
    input logic              rsp_last,
    input logic [NBANK-1:0]  bank_rdy,
    input logic [WIDX_W-1:0] word_idx
);

    int   cyc;
    int   wcnt;
    logic c_seq;
    logic c_we;
    logic acc;

    assign acc = req_valid && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc   <= 0;
            wcnt  <= 0;
            c_seq <= 1'b0;
            c_we  <= 1'b0;
        end else if (acc) begin
            cyc   <= 0;
            wcnt  <= 0;
            c_seq <= FORCE_SEQ || seq_mode;
            c_we  <= req_we;
        end else begin
            if (cyc < 1000000) begin
                cyc <= cyc + 1;
            end
            if (rsp_valid) begin
                wcnt <= wcnt + 1;
            end
        end
    end

    AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> busy); // R2

    AST_ILV_WORD_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !c_seq) |-> (cyc == ACC_LAT + wcnt)); // R3

    AST_BANK_DATA_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> bank_rdy[word_idx]); // R4

    AST_SEQ_WORD_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && c_seq) |-> (cyc == (wcnt + 1) * ACC_LAT + wcnt)); // R5

    AST_LAST_ON_FOURTH: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_last == (wcnt == NBANK - 1))); // R6

    AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |=> !busy); // R7

    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !c_we); // R9

endmodule

bind ilv_block_fetch ilv_block_fetch_chk #(
    .ACC_LAT   (ACC_LAT),
    .FORCE_SEQ (FORCE_SEQ)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_we    (req_we),
    .seq_mode  (seq_mode),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .rsp_last  (rsp_last),
    .bank_rdy  (bank_rdy),
    .word_idx  (word_idx)
);

// File: tb/ilv_block_fetch_tb_top.sv
`timescale 1ns/1ps
module ilv_block_fetch_tb_top;

    localparam int DW   = 16;
    localparam int AW   = 6;
    localparam int LAT  = 15;
    localparam int FLAT = 3;

    // {we, seq, addr[5:0], base[15:0]}
    localparam logic [23:0] VEC [8] = '{
        24'h85A500, 24'hFF3C00, 24'h801200, 24'h050000,
        24'h7F0000, 24'h400000, 24'h450000, 24'h3F0000
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          seq_mode = 1'b0;
    logic          rv = 1'b0;
    logic          sel = 1'b0;
    logic          req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [4*DW-1:0] req_wdata = '0;

    logic          busy_a, val_a, last_a;
    logic [DW-1:0] data_a;
    logic          busy_b, val_b, last_b;
    logic [DW-1:0] data_b;

    int errs = 0;
    int checks = 0;
    logic [DW-1:0] mdl [2][64][4];

    always #5 clk = ~clk;

    ilv_block_fetch #(.DW(DW), .AW(AW), .ACC_LAT(LAT), .FORCE_SEQ(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .seq_mode(seq_mode), .req_valid(rv && !sel),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy_a), .rsp_valid(val_a), .rsp_last(last_a), .rsp_data(data_a));

    ilv_block_fetch #(.DW(DW), .AW(AW), .ACC_LAT(FLAT), .FORCE_SEQ(1'b1)) dut_fs_i (
        .clk(clk), .rst_n(rst_n), .seq_mode(seq_mode), .req_valid(rv && sel),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy_b), .rsp_valid(val_b), .rsp_last(last_b), .rsp_data(data_b));

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] wword(input logic [DW-1:0] base, input int k);
        return base + DW'(k) * 16'h0101;
    endfunction

    task automatic run_txn(input bit s, input bit we, input bit sq, input int addr,
                           input logic [DW-1:0] base, input bit noisy, input bit flip,
                           input string ttag, input string dtag);
        int lat = s ? FLAT : LAT;
        bit esq = s ? 1'b1 : sq;
        int n = 0;
        int busy_rel = -1;
        int wrel [4];
        logic [DW-1:0] wdat [4];
        bit wlast [4];
        @(negedge clk);
        sel = s;
        rv = 1'b1;
        req_we = we;
        seq_mode = sq;
        req_addr = AW'(addr);
        for (int k = 0; k < 4; k++) req_wdata[k*DW +: DW] = wword(base, k);
        @(negedge clk);
        rv = 1'b0;
        for (int rel = 0; rel < 4 * lat + 12; rel++) begin
            logic b, v, l;
            logic [DW-1:0] d;
            if (flip && rel == 1) seq_mode = !sq;
            if (noisy && rel == 2) begin
                rv = 1'b1;
                req_we = 1'b1;
                req_addr = '0;
                for (int k = 0; k < 4; k++) req_wdata[k*DW +: DW] = 16'hDEAD;
            end
            if (noisy && rel == 8) rv = 1'b0;
            b = s ? busy_b : busy_a;
            v = s ? val_b : val_a;
            l = s ? last_b : last_a;
            d = s ? data_b : data_a;
            if (rel == 0) chk(b == 1'b1, "R2", "busy after accept", int'(b), 1);
            if (v) begin
                if (n < 4) begin
                    wrel[n] = rel;
                    wdat[n] = d;
                    wlast[n] = l;
                end
                n++;
            end
            if (!b && busy_rel < 0) busy_rel = rel;
            @(negedge clk);
        end
        seq_mode = 1'b0;
        chk(busy_rel == (esq ? 4 * lat + 4 : lat + 4), we ? "R9" : "R7",
            "busy release slot", busy_rel, esq ? 4 * lat + 4 : lat + 4);
        if (we) begin
            chk(n == 0, "R9", "strobes on write", n, 0);
            for (int k = 0; k < 4; k++) mdl[s][addr][k] = wword(base, k);
        end else begin
            chk(n == 4, "R6", "strobe count", n, 4);
            for (int k = 0; k < 4 && k < n; k++) begin
                int er = esq ? (k + 1) * lat + k : lat + k;
                chk(wrel[k] == er, ttag, "word slot", wrel[k], er);
                chk(wdat[k] === mdl[s][addr][k], dtag, "word data",
                    int'(wdat[k]), int'(mdl[s][addr][k]));
                chk(wlast[k] == (k == 3), "R6", "last flag", int'(wlast[k]), int'(k == 3));
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state on both builds
        chk(busy_a == 1'b0 && busy_b == 1'b0, "R1", "busy after reset", int'(busy_a | busy_b), 0);
        chk(val_a == 1'b0 && val_b == 1'b0, "R1", "rsp_valid after reset", int'(val_a | val_b), 0);
        chk(last_a == 1'b0 && last_b == 1'b0, "R1", "rsp_last after reset", int'(last_a | last_b), 0);

        // Vector table: writes then reads in both modes (R3, R4, R5, R9)
        for (int i = 0; i < 8; i++) begin
            logic [23:0] e = VEC[i];
            run_txn(1'b0, e[23], e[22], int'(e[21:16]), e[15:0], 1'b0, 1'b0,
                    e[22] ? "R5" : "R3", "R4");
        end

        // R7: conflicting write raised while busy must be ignored
        run_txn(1'b0, 1'b0, 1'b0, 5, 16'h0, 1'b1, 1'b0, "R7", "R7");
        run_txn(1'b0, 1'b0, 1'b0, 0, 16'h0, 1'b0, 1'b0, "R3", "R7");

        // R8: mode toggled mid-transfer keeps acceptance-time timing
        run_txn(1'b0, 1'b0, 1'b0, 63, 16'h0, 1'b0, 1'b1, "R8", "R4");
        run_txn(1'b0, 1'b0, 1'b1, 5, 16'h0, 1'b0, 1'b1, "R8", "R4");

        // R10: build with sequential timing forced
        run_txn(1'b1, 1'b1, 1'b0, 10, 16'h7700, 1'b0, 1'b0, "R10", "R10");
        run_txn(1'b1, 1'b0, 1'b0, 10, 16'h0, 1'b0, 1'b0, "R10", "R10");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule